// File: doc/BRIEF.md
# Triggered Hit Buffer with Timestamps

This block sits in the periphery of one double column of a zero-suppressed pixel readout chip. Time is divided into bunch crossings. A crossing starts after a cycle with `bxTick` high and ends with the next cycle that has `bxTick` high. Every hit presented in the cycles of a crossing, the closing `bxTick` cycle included, belongs to that crossing. The first hit of a crossing claims an entry in a small timestamp pool, and that entry records the current value of an 8-bit crossing counter. Every hit, the first one included, takes a slot in a separate data pool. The slot holds the pixel address, the pulse height and a pointer to its timestamp entry.

Each timestamp entry waits a fixed latency of `LATENCY` crossings. A trigger pulse seen during crossing N+`LATENCY` marks the entry stamped N for readout. If no trigger comes, the entry and every data slot linked to it are freed when crossing N+`LATENCY` closes. Marked data leaves only while the block holds the readout token. For each token it receives, the block sends the hits of one marked crossing, one word per cycle, and then passes the token on. Hit capture continues while a readout is running. A hit that finds either pool full is dropped, and a saturating loss counter for that pool is incremented.

Top module: `trig_hit_buffer`

## Requirements
- R1: After reset, `outValid` and `tokenOut` are 0, both loss counters are 0 and the crossing counter starts at 0.
- R2: A hit stored in crossing N is kept when `trigger` is high in any cycle of crossing N+LATENCY. It is read out with `outStamp` = N mod 2^BC_W and with its own address and pulse height. The first word appears in the cycle after the cycle in which `tokenIn` is sampled high.
- R3: A trigger in any crossing other than N+LATENCY, or no trigger at all, does not keep the hit. The entry and all of its hits are discarded when crossing N+LATENCY closes, so a later token produces no data words.
- R4: All hits of one crossing share one timestamp entry. They are read on consecutive cycles, one word per cycle with `outValid` high, all carrying the same stamp. Starting from an empty data pool, they come out in arrival order.
- R5: `tokenOut` is a one-cycle pulse. It comes in the cycle after the last data word, or, if no marked entry exists, in the cycle after `tokenIn` was sampled.
- R6: A hit opening a new crossing while all TS_DEPTH timestamp entries are in use is dropped and increments `tsLossCount` by one.
- R7: A hit arriving while all DATA_DEPTH data slots are in use is dropped and increments `dataLossCount` by one.
- R8: One token pass sends the hits of exactly one marked crossing, and the oldest marked crossing goes first. A second token sends the next one.
- R9: A hit presented during a readout is stored and can be triggered and read out later.
- R10: The crossing counter wraps modulo 2^BC_W. The latency match and the reported stamp work across the wrap.
- R11: Entries freed by expiry or readout are reusable: after expiry, a full pool's worth of new hits is stored with no loss.
- R12: A `tokenIn` pulse that arrives while a readout is in progress is ignored. It changes neither the words sent nor the number of `tokenOut` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bxTick | input | 1 | Closes the current crossing; the counter advances at this edge |
| hitValid | input | 1 | A pixel hit is presented this cycle |
| hitAddr | input | ADDR_W | Pixel address of the hit |
| hitPh | input | PH_W | Pulse-height word of the hit |
| trigger | input | 1 | Trigger for the crossing LATENCY crossings back |
| tokenIn | input | 1 | Readout token arrives (one-cycle pulse) |
| tokenOut | output | 1 | Token passed on (one-cycle pulse) |
| outValid | output | 1 | A data word is on the output this cycle |
| outStamp | output | BC_W | Crossing number of the word being read |
| outAddr | output | ADDR_W | Pixel address of the word being read |
| outPh | output | PH_W | Pulse height of the word being read |
| tsLossCount | output | CNT_W | Hits dropped because the timestamp pool was full |
| dataLossCount | output | CNT_W | Hits dropped because the data pool was full |

## Verification
The hardest situations to reach are the exact decision boundary and the wrap of the crossing counter. A trigger one crossing early or one crossing late must lose the hit, and a stamp taken just before the counter wraps must still match. The bench sweeps the trigger offset across a window around the latency, each time from an empty pool. It then walks the counter up to a few crossings below the wrap before placing a hit. Pool exhaustion is reached with a small bench configuration of four timestamp entries and eight data slots. Readouts are run with `bxTick` held low, so no entry ages while words are being checked.

// File: rtl/hitbuf_pkg.sv
package hitbuf_pkg;

  typedef enum logic [1:0] {
    TK_IDLE,
    TK_READ,
    TK_PASS
  } tokState_t;

  // Strobes from control to the data pool.
  typedef struct packed {
    logic store;   // write incoming hit into the first free slot
    logic pop;     // free the slot currently presented for readout
    logic purge;   // free every slot linked to purgeTs
  } dpStrobe_t;

endpackage

// File: rtl/hitbuf_dpath.sv
module hitbuf_dpath
  import hitbuf_pkg::*;
#(
  parameter int DATA_DEPTH = 32,
  parameter int TS_IDX_W   = 4,
  parameter int ADDR_W     = 9,
  parameter int PH_W       = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [TS_IDX_W-1:0] wrTs,
  input  logic [TS_IDX_W-1:0] purgeTs,
  input  logic [TS_IDX_W-1:0] selTs,
  input  logic [ADDR_W-1:0]   hitAddr,
  input  logic [PH_W-1:0]     hitPh,
  output logic                dataFree,
  output logic                rdFound,
  output logic [ADDR_W-1:0]   rdAddr,
  output logic [PH_W-1:0]     rdPh
);

  localparam int D_IDX_W = (DATA_DEPTH > 1) ? $clog2(DATA_DEPTH) : 1;

  logic                slotUsed [DATA_DEPTH];
  logic [TS_IDX_W-1:0] slotTs   [DATA_DEPTH];
  logic [ADDR_W-1:0]   slotAddr [DATA_DEPTH];
  logic [PH_W-1:0]     slotPh   [DATA_DEPTH];
  logic [D_IDX_W-1:0]  freeIdx, rdIdx;

  // Lowest free slot and lowest used slot linked to the selected timestamp.
  always_comb begin
    dataFree = 1'b0;
    freeIdx  = '0;
    rdFound  = 1'b0;
    rdIdx    = '0;
    for (int i = DATA_DEPTH - 1; i >= 0; i--) begin
      if (!slotUsed[i]) begin
        dataFree = 1'b1;
        freeIdx  = D_IDX_W'(i);
      end
      if (slotUsed[i] && slotTs[i] == selTs) begin
        rdFound = 1'b1;
        rdIdx   = D_IDX_W'(i);
      end
    end
  end

  assign rdAddr = slotAddr[rdIdx];
  assign rdPh   = slotPh[rdIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DATA_DEPTH; i++) begin
        slotUsed[i] <= 1'b0;
        slotTs[i]   <= '0;
        slotAddr[i] <= '0;
        slotPh[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < DATA_DEPTH; i++) begin
        if (strobe.store && freeIdx == D_IDX_W'(i)) begin
          slotUsed[i] <= 1'b1;
          slotTs[i]   <= wrTs;
          slotAddr[i] <= hitAddr;
          slotPh[i]   <= hitPh;
        end else if ((strobe.pop && rdIdx == D_IDX_W'(i)) ||
                     (strobe.purge && slotTs[i] == purgeTs)) begin
          slotUsed[i] <= 1'b0;
        end
      end
    end
  end

  AST_STORE_HAS_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    strobe.store |-> dataFree);  // R7
  AST_POP_HAS_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> rdFound);  // R8

endmodule

// File: rtl/hitbuf_ctl.sv
module hitbuf_ctl
  import hitbuf_pkg::*;
#(
  parameter int TS_DEPTH   = 12,
  parameter int DATA_DEPTH = 32,
  parameter int LATENCY    = 128,
  parameter int BC_W       = 8,
  parameter int CNT_W      = 16,
  parameter int TS_IDX_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bxTick,
  input  logic                hitValid,
  input  logic                trigger,
  input  logic                tokenIn,
  input  logic                dataFree,
  input  logic                rdFound,
  output dpStrobe_t           strobe,
  output logic [TS_IDX_W-1:0] wrTs,
  output logic [TS_IDX_W-1:0] purgeTs,
  output logic [TS_IDX_W-1:0] selTs,
  output logic                tokenOut,
  output logic                outValid,
  output logic [BC_W-1:0]     outStamp,
  output logic [CNT_W-1:0]    tsLossCount,
  output logic [CNT_W-1:0]    dataLossCount
);

  localparam int             HIT_W  = $clog2(DATA_DEPTH + 1);
  localparam logic [BC_W-1:0] LAT_BC = BC_W'(LATENCY);

  logic [BC_W-1:0]     bcCount;
  logic                tsUsed  [TS_DEPTH];
  logic                tsTrig  [TS_DEPTH];
  logic [BC_W-1:0]     tsStamp [TS_DEPTH];
  logic [HIT_W-1:0]    tsHits  [TS_DEPTH];
  logic [BC_W-1:0]     age     [TS_DEPTH];
  logic                atDecision [TS_DEPTH];
  logic [TS_IDX_W-1:0] curTs, tsFreeIdx, oldIdx;
  logic [BC_W-1:0]     oldAge;
  logic                curOpen, tsFreeAny, expireAny, trigAny;
  logic                tsBlock, dataBlock, doStore, doPurge, doPop;
  tokState_t           state;

  always_comb begin
    tsFreeAny = 1'b0;
    tsFreeIdx = '0;
    expireAny = 1'b0;
    purgeTs   = '0;
    for (int k = TS_DEPTH - 1; k >= 0; k--) begin
      age[k]        = bcCount - tsStamp[k];
      atDecision[k] = tsUsed[k] && (age[k] == LAT_BC);
      if (!tsUsed[k]) begin
        tsFreeAny = 1'b1;
        tsFreeIdx = TS_IDX_W'(k);
      end
      if (atDecision[k] && !tsTrig[k]) begin
        expireAny = 1'b1;
        purgeTs   = TS_IDX_W'(k);
      end
    end
    // Oldest marked entry goes out first.
    trigAny = 1'b0;
    oldIdx  = '0;
    oldAge  = '0;
    for (int k = 0; k < TS_DEPTH; k++) begin
      if (tsUsed[k] && tsTrig[k] && (!trigAny || age[k] > oldAge)) begin
        trigAny = 1'b1;
        oldIdx  = TS_IDX_W'(k);
        oldAge  = age[k];
      end
    end
  end

  assign tsBlock   = hitValid && !curOpen && !tsFreeAny;
  assign dataBlock = hitValid && !tsBlock && !dataFree;
  assign doStore   = hitValid && !tsBlock && dataFree;
  assign wrTs      = curOpen ? curTs : tsFreeIdx;
  assign doPurge   = bxTick && expireAny && !trigger;
  assign doPop     = (state == TK_READ);

  assign strobe   = '{store: doStore, pop: doPop, purge: doPurge};
  assign tokenOut = (state == TK_PASS);
  assign outValid = (state == TK_READ);
  assign outStamp = tsStamp[selTs];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bcCount       <= '0;
      curOpen       <= 1'b0;
      curTs         <= '0;
      selTs         <= '0;
      state         <= TK_IDLE;
      tsLossCount   <= '0;
      dataLossCount <= '0;
      for (int k = 0; k < TS_DEPTH; k++) begin
        tsUsed[k]  <= 1'b0;
        tsTrig[k]  <= 1'b0;
        tsStamp[k] <= '0;
        tsHits[k]  <= '0;
      end
    end else begin
      if (bxTick) bcCount <= bcCount + 1'b1;

      if (bxTick) curOpen <= 1'b0;
      else if (doStore && !curOpen) begin
        curOpen <= 1'b1;
        curTs   <= tsFreeIdx;
      end

      for (int k = 0; k < TS_DEPTH; k++) begin
        if (doStore && wrTs == TS_IDX_W'(k)) begin
          if (!curOpen) begin
            tsUsed[k]  <= 1'b1;
            tsTrig[k]  <= 1'b0;
            tsStamp[k] <= bcCount;
            tsHits[k]  <= HIT_W'(1);
          end else begin
            tsHits[k] <= tsHits[k] + 1'b1;
          end
        end else if (doPurge && purgeTs == TS_IDX_W'(k)) begin
          tsUsed[k] <= 1'b0;
        end else if (doPop && selTs == TS_IDX_W'(k)) begin
          tsHits[k] <= tsHits[k] - 1'b1;
          if (tsHits[k] == HIT_W'(1)) tsUsed[k] <= 1'b0;
        end
        if (trigger && atDecision[k]) tsTrig[k] <= 1'b1;
      end

      case (state)
        TK_IDLE: if (tokenIn) begin
          if (trigAny) begin
            state <= TK_READ;
            selTs <= oldIdx;
          end else begin
            state <= TK_PASS;
          end
        end
        TK_READ: if (tsHits[selTs] == HIT_W'(1)) state <= TK_PASS;
        default: state <= TK_IDLE;
      endcase

      if (tsBlock && tsLossCount != '1) tsLossCount <= tsLossCount + 1'b1;
      if (dataBlock && dataLossCount != '1) dataLossCount <= dataLossCount + 1'b1;
    end
  end

  AST_READ_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> rdFound);  // R4
  AST_STAMP_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |-> $stable(outStamp));  // R4
  AST_TS_LOSS_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (tsLossCount != $past(tsLossCount)) |-> $past(!tsFreeAny && hitValid));  // R6
  AST_DATA_LOSS_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (dataLossCount != $past(dataLossCount)) |-> $past(!dataFree));  // R7
  AST_TOKEN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    tokenOut |=> !tokenOut);  // R5

endmodule

// File: rtl/trig_hit_buffer.sv
module trig_hit_buffer
  import hitbuf_pkg::*;
#(
  parameter int DATA_DEPTH = 32,
  parameter int TS_DEPTH   = 12,
  parameter int LATENCY    = 128,
  parameter int BC_W       = 8,
  parameter int ADDR_W     = 9,
  parameter int PH_W       = 8,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bxTick,
  input  logic              hitValid,
  input  logic [ADDR_W-1:0] hitAddr,
  input  logic [PH_W-1:0]   hitPh,
  input  logic              trigger,
  input  logic              tokenIn,
  output logic              tokenOut,
  output logic              outValid,
  output logic [BC_W-1:0]   outStamp,
  output logic [ADDR_W-1:0] outAddr,
  output logic [PH_W-1:0]   outPh,
  output logic [CNT_W-1:0]  tsLossCount,
  output logic [CNT_W-1:0]  dataLossCount
);

  localparam int TS_IDX_W = (TS_DEPTH > 1) ? $clog2(TS_DEPTH) : 1;

  dpStrobe_t           strobe;
  logic [TS_IDX_W-1:0] wrTs, purgeTs, selTs;
  logic                dataFree, rdFound;

  hitbuf_ctl #(
    .TS_DEPTH(TS_DEPTH), .DATA_DEPTH(DATA_DEPTH), .LATENCY(LATENCY),
    .BC_W(BC_W), .CNT_W(CNT_W), .TS_IDX_W(TS_IDX_W)
  ) i_ctl (
    .clk(clk), .rstN(rstN), .bxTick(bxTick), .hitValid(hitValid),
    .trigger(trigger), .tokenIn(tokenIn), .dataFree(dataFree), .rdFound(rdFound),
    .strobe(strobe), .wrTs(wrTs), .purgeTs(purgeTs), .selTs(selTs),
    .tokenOut(tokenOut), .outValid(outValid), .outStamp(outStamp),
    .tsLossCount(tsLossCount), .dataLossCount(dataLossCount)
  );

  hitbuf_dpath #(
    .DATA_DEPTH(DATA_DEPTH), .TS_IDX_W(TS_IDX_W), .ADDR_W(ADDR_W), .PH_W(PH_W)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrTs(wrTs), .purgeTs(purgeTs),
    .selTs(selTs), .hitAddr(hitAddr), .hitPh(hitPh), .dataFree(dataFree),
    .rdFound(rdFound), .rdAddr(outAddr), .rdPh(outPh)
  );

endmodule

// File: tb/test_trig_hit_buffer.sv
module test_trig_hit_buffer;

  localparam int LAT = 16;
  localparam int TSD = 4;
  localparam int DD  = 8;
  localparam int AW  = 9;
  localparam int PW  = 8;
  localparam int CW  = 16;

  logic clk = 1'b0, rstN = 1'b0, bxTick = 1'b0, hitValid = 1'b0;
  logic trigger = 1'b0, tokenIn = 1'b0;
  logic [AW-1:0] hitAddr = '0;
  logic [PW-1:0] hitPh = '0;
  logic tokenOut, outValid;
  logic [7:0] outStamp;
  logic [AW-1:0] outAddr;
  logic [PW-1:0] outPh;
  logic [CW-1:0] tsLossCount, dataLossCount;

  int nCheck = 0, nFail = 0, bcModel = 0;
  int expAddr [16];

  trig_hit_buffer #(
    .DATA_DEPTH(DD), .TS_DEPTH(TSD), .LATENCY(LAT), .BC_W(8),
    .ADDR_W(AW), .PH_W(PW), .CNT_W(CW)
  ) i_trig_hit_buffer (
    .clk(clk), .rstN(rstN), .bxTick(bxTick), .hitValid(hitValid),
    .hitAddr(hitAddr), .hitPh(hitPh), .trigger(trigger), .tokenIn(tokenIn),
    .tokenOut(tokenOut), .outValid(outValid), .outStamp(outStamp),
    .outAddr(outAddr), .outPh(outPh), .tsLossCount(tsLossCount),
    .dataLossCount(dataLossCount)
  );

  always #10 clk = ~clk;

  function automatic int phOf(int a);
    return (a * 5 + 3) % 256;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nCheck++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(bit hv, int ad, bit bx, bit tr, bit tk);
    @(negedge clk);
    hitValid = hv;
    hitAddr  = AW'(ad);
    hitPh    = PW'(phOf(ad));
    bxTick   = bx;
    trigger  = tr;
    tokenIn  = tk;
  endtask

  // One crossing carrying nh hits (addresses base, base+1, ...).
  task automatic crossing(int nh, bit trg, int base);
    int len = (nh > 0) ? nh : 1;
    for (int i = 0; i < len; i++)
      drive(i < nh, base + i, i == len - 1, trg && i == 0, 1'b0);
    bcModel++;
  endtask

  task automatic idleCrossings(int n);
    for (int i = 0; i < n; i++) crossing(0, 1'b0, 0);
  endtask

  // Token pass expecting n words with the given stamp and expAddr[].
  task automatic readout(string req, int n, int stamp, bit injHit, bit dupTok);
    drive(1'b0, 0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < n; i++) begin
      drive(injHit && i == 0, 55, 1'b0, 1'b0, dupTok && i == 0);
      check(req, "outValid", 32'(outValid), 1);
      check(req, "outStamp", 32'(outStamp), stamp % 256);
      check(req, "outAddr", 32'(outAddr), expAddr[i]);
      check(req, "outPh", 32'(outPh), phOf(expAddr[i]));
      check(req, "tokenOut during read", 32'(tokenOut), 0);
    end
    drive(1'b0, 0, 1'b0, 1'b0, 1'b0);
    check(req, "tokenOut pulse (R5)", 32'(tokenOut), 1);
    check(req, "outValid after words", 32'(outValid), 0);
    drive(1'b0, 0, 1'b0, 1'b0, 1'b0);
    check(req, "tokenOut single (R5)", 32'(tokenOut), 0);
    check(req, "no extra word", 32'(outValid), 0);
  endtask

  initial begin
    #(20 * 200000);
    nFail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
    $finish;
  end

  initial begin
    int h;
    int c0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "outValid", 32'(outValid), 0);
    check("R1", "tokenOut", 32'(tokenOut), 0);
    check("R1", "tsLossCount", 32'(tsLossCount), 0);
    check("R1", "dataLossCount", 32'(dataLossCount), 0);
    rstN = 1'b1;

    // R5 empty pool: immediate pass
    readout("R5", 0, 0, 1'b0, 1'b0);

    // R2 / R3 sweep of trigger offset around the latency
    for (int d = 0; d <= LAT + 3; d++) begin
      int last = (d > LAT) ? d : LAT;
      h = bcModel;
      for (int c = 0; c <= last; c++) crossing((c == 0) ? 1 : 0, c == d, 20 + d);
      if (d == LAT) begin
        expAddr[0] = 20 + d;
        readout("R2", 1, h, 1'b0, 1'b0);
      end else begin
        readout("R3", 0, 0, 1'b0, 1'b0);
      end
    end

    // R10 wrap of the crossing counter
    while (bcModel % 256 != 250) crossing(0, 1'b0, 0);
    h = bcModel;
    for (int c = 0; c <= LAT; c++) crossing((c == 0) ? 1 : 0, c == LAT, 77);
    expAddr[0] = 77;
    readout("R10", 1, h, 1'b0, 1'b0);

    // R4 several hits in one crossing; R12 duplicate token ignored
    h = bcModel;
    crossing(3, 1'b0, 100);
    for (int c = 1; c <= LAT; c++) crossing(0, c == LAT, 0);
    for (int i = 0; i < 3; i++) expAddr[i] = 100 + i;
    readout("R4 R12", 3, h, 1'b0, 1'b1);

    // R8 two marked crossings, oldest first, one per token
    h = bcModel;
    crossing(2, 1'b0, 120);
    crossing(1, 1'b0, 130);
    for (int c = 2; c <= LAT + 1; c++) crossing(0, c == LAT || c == LAT + 1, 0);
    expAddr[0] = 120; expAddr[1] = 121;
    readout("R8", 2, h, 1'b0, 1'b0);
    expAddr[0] = 130;
    readout("R8", 1, h + 1, 1'b0, 1'b0);

    // R6 timestamp pool full
    for (int i = 0; i < TSD + 1; i++) crossing(1, 1'b0, 140 + i);
    drive(1'b0, 0, 1'b0, 1'b0, 1'b0);
    check("R6", "tsLossCount", 32'(tsLossCount), 1);
    check("R6", "dataLossCount", 32'(dataLossCount), 0);
    idleCrossings(LAT + 1);
    readout("R11", 0, 0, 1'b0, 1'b0);
    // R11 capacity restored after expiry
    for (int i = 0; i < TSD; i++) crossing(1, 1'b0, 150 + i);
    drive(1'b0, 0, 1'b0, 1'b0, 1'b0);
    check("R11", "tsLossCount unchanged", 32'(tsLossCount), 1);
    idleCrossings(LAT + 1);

    // R7 data pool full within one crossing
    crossing(DD + 1, 1'b0, 160);
    drive(1'b0, 0, 1'b0, 1'b0, 1'b0);
    check("R7", "dataLossCount", 32'(dataLossCount), 1);
    check("R7", "tsLossCount", 32'(tsLossCount), 1);
    idleCrossings(LAT + 1);
    readout("R3", 0, 0, 1'b0, 1'b0);
    crossing(DD, 1'b0, 180);
    drive(1'b0, 0, 1'b0, 1'b0, 1'b0);
    check("R11", "dataLossCount unchanged", 32'(dataLossCount), 1);
    idleCrossings(LAT + 1);

    // R9 capture during readout
    h = bcModel;
    crossing(1, 1'b0, 170);
    for (int c = 1; c <= LAT; c++) crossing(0, c == LAT, 0);
    c0 = bcModel;
    expAddr[0] = 170;
    readout("R9", 1, h, 1'b1, 1'b0);
    for (int c = 0; c <= LAT; c++) crossing(0, c == LAT, 0);
    expAddr[0] = 55;
    readout("R9", 1, c0, 1'b0, 1'b0);
    check("R9", "dataLossCount", 32'(dataLossCount), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
    $finish;
  end

endmodule